// File: doc/BRIEF.md
# Word FIFO with Byte Serializer

This block carries a data payload between a host that reads and writes 32-bit words and a card port that moves one byte at a time. Between them sits a small word FIFO. In the receive direction, bytes from the card are assembled into words and pushed into the FIFO, and the host pops them. In the transmit direction, the host pushes words, and the block pops them and hands them out one byte per card handshake.

A transfer starts with a single load pulse. The pulse carries a byte length, a direction bit and an enable bit. The block counts the remaining bytes down to zero. Once nothing is left to move and the FIFO has drained, it switches itself off. While it runs, it reports occupancy flags, and only the flag group for the active direction is visible.

Top module: `wfifo_byte_mover`

## Requirements
- R1: The FIFO holds 16 words of 32 bits and returns them in push order, including after its pointers wrap past entry 15. A host pop and an internal push in the same cycle leave the occupancy unchanged.
- R2: A push while 16 words are held is dropped. A pop while empty returns zero and changes nothing.
- R3: Receive packing is little-endian. The first byte of each group of four lands in bits 7:0, then bits 15:8, then 23:16, then 31:24.
- R4: When the receive count reaches zero with 1 to 3 bytes collected, those bytes are pushed as one word with the unused upper bytes zero.
- R5: A card byte is accepted (`card_in_ack` high) only while receiving with a nonzero count, `card_rdy` high and the FIFO not full. Otherwise the count holds.
- R6: Transmit sends each word low byte first, one byte per `card_out_valid`/`card_out_ready` handshake. `card_out_valid` stays low once the count is zero, even if bytes of the current word remain unsent. A byte offered and not taken stays unchanged.
- R7: `byte_left` drops by exactly one for each byte moved to or from the card.
- R8: A load with the enable bit set puts the length into `byte_left` and discards any partly assembled receive word and any unsent transmit bytes.
- R9: `data_end` is high when a transfer has been started by an enabled load and `byte_left` is zero. It is low after reset.
- R10: `eng_en` is set by an enabled load. It clears itself one cycle after the count is zero with the FIFO empty. When the count is zero and the FIFO is empty, all flags read zero.
- R11: Each flag group is laid out as bit 0 active, bit 1 threshold, bit 2 full (16 words), bit 3 empty (0 words), bit 4 data available (nonzero). The threshold bit means 8 or more words for receive and 8 or fewer for transmit.
- R12: While the engine runs, only `stat_rx` can be nonzero in the receive direction and only `stat_tx` in the transmit direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_load | input | 1 | Load pulse for a transfer setting |
| xfer_len | input | 16 | Byte length taken on an enabled load |
| xfer_rx | input | 1 | Direction taken on load: 1 receive, 0 transmit |
| xfer_en | input | 1 | Enable bit taken on load |
| h_push | input | 1 | Host word push |
| h_wdata | input | 32 | Host word to push |
| h_pop | input | 1 | Host word pop |
| h_rdata | output | 32 | FIFO head word, zero when empty |
| card_rdy | input | 1 | Card has a receive byte ready |
| card_in_data | input | 8 | Receive byte from the card |
| card_in_ack | output | 1 | Receive byte accepted this cycle |
| card_out_data | output | 8 | Transmit byte to the card |
| card_out_valid | output | 1 | Transmit byte offered |
| card_out_ready | input | 1 | Card takes the offered byte |
| byte_left | output | 16 | Remaining byte count |
| eng_en | output | 1 | Engine enable state |
| data_end | output | 1 | Count reached zero after a start |
| stat_rx | output | 5 | Receive flag group |
| stat_tx | output | 5 | Transmit flag group |

## Verification
The receive packer can complete a word and push it in the same cycle that the host pops the FIFO head. If either side is dropped, the occupancy drifts by one. The bench provokes this with the FIFO at 15 words. It raises `h_pop` together with the fourth byte of a word. It then delivers one more full word and requires the full flag to be set, with every popped word matching its scoreboard entry in order. A second case offers a byte while the FIFO is full and requires it to be refused without any change to the count.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  // Occupancy flag group, one per direction; MSB first.
  typedef struct packed {
    logic avail;
    logic empty;
    logic full;
    logic thresh;
    logic active;
  } wfs_flags_t;
endpackage

// File: rtl/wfs_word_fifo.sv
module wfs_word_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     pop,
  output logic [DATA_W-1:0]        rdata,
  output logic [$clog2(DEPTH):0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_L = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   lvl_q, lvl_d;
  logic          do_push, do_pop;

  always_comb begin
    do_push = push && (lvl_q != FULL_L);
    do_pop  = pop && (lvl_q != '0);
    wp_d    = do_push ? wp_q + AW'(1) : wp_q;
    rp_d    = do_pop  ? rp_q + AW'(1) : rp_q;
    lvl_d   = lvl_q;
    if (do_push && !do_pop) lvl_d = lvl_q + (AW+1)'(1);
    if (do_pop && !do_push) lvl_d = lvl_q - (AW+1)'(1);
    rdata   = (lvl_q != '0) ? mem[rp_q] : '0;
    level   = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_L);
  // R2
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && level == FULL_L) |=> level == FULL_L);
  // R2
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && level == '0) |=> level == '0);
endmodule

// File: rtl/wfs_byte_packer.sv
module wfs_byte_packer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              last,
  input  logic [7:0]        byte_in,
  output logic              push,
  output logic [DATA_W-1:0] word_out
);
  localparam int LANES = DATA_W / 8;
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [DATA_W-1:0] acc_q, acc_d;
  logic [IW-1:0]     idx_q, idx_d;

  always_comb begin
    word_out = acc_q;
    for (int i = 0; i < LANES; i++) begin
      if (idx_q == IW'(i)) word_out[i*8 +: 8] = byte_in;
    end
    push  = take && (last || idx_q == IW'(LANES-1));
    acc_d = acc_q;
    idx_d = idx_q;
    if (clr || (take && push)) begin
      acc_d = '0;
      idx_d = '0;
    end else if (take) begin
      acc_d = word_out;
      idx_d = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else begin
      acc_q <= acc_d;
      idx_q <= idx_d;
    end
  end

  // R4
  flush_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> (idx_q == '0 && acc_q == '0));
endmodule

// File: rtl/wfs_byte_unpacker.sv
module wfs_byte_unpacker #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fill,
  input  logic [DATA_W-1:0] word_in,
  input  logic              shift,
  output logic              has,
  output logic [7:0]        byte_out
);
  localparam int LANES = DATA_W / 8;
  localparam int CW    = $clog2(LANES + 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     left_q, left_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (clr) begin
      left_d = '0;
    end else if (fill) begin
      sh_d   = word_in;
      left_d = CW'(LANES);
    end else if (shift) begin
      sh_d   = sh_q >> 8;
      left_d = left_q - CW'(1);
    end
    has      = (left_q != '0);
    byte_out = sh_q[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/wfifo_byte_mover.sv
module wfifo_byte_mover #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_load,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_rx,
  input  logic              xfer_en,
  input  logic              h_push,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              h_pop,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              card_rdy,
  input  logic [7:0]        card_in_data,
  output logic              card_in_ack,
  output logic [7:0]        card_out_data,
  output logic              card_out_valid,
  input  logic              card_out_ready,
  output logic [LEN_W-1:0]  byte_left,
  output logic              eng_en,
  output logic              data_end,
  output logic [4:0]        stat_rx,
  output logic [4:0]        stat_tx
);
  import wfs_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_L = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_L = (AW+1)'(DEPTH / 2);

  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              en_q, en_d, rx_q, rx_d, seen_q, seen_d;
  logic [AW:0]       level;
  logic [DATA_W-1:0] f_rdata, f_wdata, pk_word;
  logic              f_push, f_pop, f_full, f_empty;
  logic              pk_push, rx_go, tx_go, fire, tx_fill, u_has, show;
  logic [7:0]        u_byte;
  wfs_flags_t        grp;

  always_comb begin
    f_full         = (level == FULL_L);
    f_empty        = (level == '0);
    rx_go          = en_q && rx_q && (cnt_q != '0) && !xfer_load;
    tx_go          = en_q && !rx_q && (cnt_q != '0) && !xfer_load;
    card_in_ack    = rx_go && card_rdy && !f_full;
    card_out_valid = tx_go && u_has;
    card_out_data  = u_byte;
    fire           = card_out_valid && card_out_ready;
    tx_fill        = tx_go && !u_has && !f_empty;
    f_push         = pk_push || h_push;
    f_wdata        = pk_push ? pk_word : h_wdata;
    f_pop          = h_pop || tx_fill;
    h_rdata        = f_rdata;

    cnt_d = cnt_q;
    if (xfer_load && xfer_en)     cnt_d = xfer_len;
    else if (card_in_ack || fire) cnt_d = cnt_q - LEN_W'(1);
    en_d = en_q;
    if (xfer_load)                                en_d = xfer_en;
    else if (en_q && cnt_q == '0 && f_empty)      en_d = 1'b0;
    rx_d   = xfer_load ? xfer_rx : rx_q;
    seen_d = xfer_load ? xfer_en : seen_q;

    show       = en_q && !(cnt_q == '0 && f_empty);
    grp.active = 1'b1;
    grp.thresh = rx_q ? (level >= HALF_L) : (level <= HALF_L);
    grp.full   = f_full;
    grp.empty  = f_empty;
    grp.avail  = !f_empty;
    stat_rx    = (show && rx_q)  ? grp : '0;
    stat_tx    = (show && !rx_q) ? grp : '0;
    byte_left  = cnt_q;
    eng_en     = en_q;
    data_end   = seen_q && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      rx_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      en_q   <= en_d;
      rx_q   <= rx_d;
      seen_q <= seen_d;
    end
  end

  wfs_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_ni), .push(f_push), .wdata(f_wdata),
    .pop(f_pop), .rdata(f_rdata), .level(level)
  );

  wfs_byte_packer #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_ni), .clr(xfer_load), .take(card_in_ack),
    .last(cnt_q == LEN_W'(1)), .byte_in(card_in_data),
    .push(pk_push), .word_out(pk_word)
  );

  wfs_byte_unpacker #(.DATA_W(DATA_W)) u_unpack (
    .clk(clk), .rst_n(rst_ni), .clr(xfer_load), .fill(tx_fill),
    .word_in(f_rdata), .shift(fire), .has(u_has), .byte_out(u_byte)
  );

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (card_in_ack || (card_out_valid && card_out_ready))
      |=> byte_left == $past(byte_left) - LEN_W'(1));
  // R10
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(eng_en) && !$past(xfer_load)) |-> $past(byte_left) == '0);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (card_out_valid && !card_out_ready && !xfer_load)
      |=> ((card_out_valid || xfer_load) && $stable(card_out_data)));
endmodule

// File: tb/tb_wfifo_byte_mover.sv
module tb_wfifo_byte_mover;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xfer_load, xfer_rx, xfer_en;
  logic [15:0] xfer_len;
  logic        h_push, h_pop;
  logic [31:0] h_wdata, h_rdata;
  logic        card_rdy, card_in_ack, card_out_valid, card_out_ready;
  logic [7:0]  card_in_data, card_out_data;
  logic [15:0] byte_left;
  logic        eng_en, data_end;
  logic [4:0]  stat_rx, stat_tx;

  always #10 clk = ~clk;

  wfifo_byte_mover dut (
    .clk(clk), .rst_n(rst_n), .xfer_load(xfer_load), .xfer_len(xfer_len),
    .xfer_rx(xfer_rx), .xfer_en(xfer_en), .h_push(h_push), .h_wdata(h_wdata),
    .h_pop(h_pop), .h_rdata(h_rdata), .card_rdy(card_rdy),
    .card_in_data(card_in_data), .card_in_ack(card_in_ack),
    .card_out_data(card_out_data), .card_out_valid(card_out_valid),
    .card_out_ready(card_out_ready), .byte_left(byte_left), .eng_en(eng_en),
    .data_end(data_end), .stat_rx(stat_rx), .stat_tx(stat_tx)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string tag = "R1";
  logic [31:0] exp_words[$];
  logic [7:0]  exp_bytes[$];

  task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // Monitor: compares popped words and sent bytes against the scoreboard.
  always @(negedge clk) begin
    logic [31:0] ew;
    logic [7:0]  eb;
    #5;
    if (rst_n && h_pop) begin
      if (exp_words.size() > 0) begin
        ew = exp_words.pop_front();
        check(h_rdata == ew, tag, h_rdata, ew);
      end else begin
        check(h_rdata == 32'h0, "R2 pop while empty", h_rdata, 32'h0);
      end
    end
    if (rst_n && card_out_valid && card_out_ready) begin
      if (exp_bytes.size() > 0) begin
        eb = exp_bytes.pop_front();
        check(card_out_data == eb, "R6 tx byte order", {24'h0, card_out_data}, {24'h0, eb});
      end else begin
        check(1'b0, "R6 unexpected tx byte", {24'h0, card_out_data}, 32'h0);
      end
    end
  end

  task automatic push_w(input logic [31:0] w);
    h_push = 1'b1; h_wdata = w;
    @(negedge clk);
    h_push = 1'b0;
  endtask

  task automatic pop_w();
    h_pop = 1'b1;
    @(negedge clk);
    h_pop = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] len, input logic rx, input logic en);
    xfer_load = 1'b1; xfer_len = len; xfer_rx = rx; xfer_en = en;
    @(negedge clk);
    xfer_load = 1'b0;
  endtask

  task automatic feed_byte(input logic [7:0] b);
    bit ok;
    ok = 1'b0;
    for (int t = 0; t < 50 && !ok; t++) begin
      card_rdy = 1'b1; card_in_data = b;
      #1 ok = card_in_ack;
      @(negedge clk);
      card_rdy = 1'b0;
    end
    if (!ok) check(1'b0, "R5 byte never accepted", {24'h0, b}, 32'h1);
  endtask

  task automatic run_tx(input int maxc);
    for (int i = 0; i < maxc && byte_left != 16'h0; i++) begin
      card_out_ready = (i % 3 != 2);
      @(negedge clk);
    end
    card_out_ready = 1'b0;
  endtask

  function automatic logic [7:0] rb(input int i);
    return 8'h40 + 8'(i);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xfer_load = 0; xfer_len = 0; xfer_rx = 0; xfer_en = 0;
    h_push = 0; h_pop = 0; h_wdata = 0; card_rdy = 0; card_in_data = 0;
    card_out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(eng_en == 1'b0, "R10 reset enable", {31'h0, eng_en}, 32'h0);
    check(byte_left == 16'h0, "R7 reset count", {16'h0, byte_left}, 32'h0);
    check(stat_rx == 5'h0 && stat_tx == 5'h0, "R12 reset flags", {22'h0, stat_rx, stat_tx}, 32'h0);
    check(data_end == 1'b0, "R9 reset data_end", {31'h0, data_end}, 32'h0);
    check(h_rdata == 32'h0, "R2 empty head", h_rdata, 32'h0);

    // R1 / R2: FIFO depth, order, overflow, underflow and wrap with engine idle
    tag = "R1 fifo order";
    for (int i = 0; i < 16; i++) begin
      push_w(32'hA000_0000 + 32'(i) * 32'h0101);
      exp_words.push_back(32'hA000_0000 + 32'(i) * 32'h0101);
    end
    push_w(32'hDEAD_BEEF);                  // R2: dropped, never expected
    for (int i = 0; i < 16; i++) pop_w();
    tag = "R2 pop empty";
    pop_w();                                // R2: expects zero
    tag = "R1 fifo wrap";
    for (int i = 0; i < 10; i++) begin
      push_w(32'h5500_0000 + 32'(i));
      exp_words.push_back(32'h5500_0000 + 32'(i));
    end
    for (int i = 0; i < 10; i++) pop_w();
    #1 check(exp_words.size() == 0, "R1 all words returned", exp_words.size(), 0);

    // R6 / R8 / R9 / R10 / R11 / R12: transmit of 10 bytes from 3 words
    push_w(32'h4433_2211); push_w(32'h8877_6655); push_w(32'hCCBB_AA99);
    for (int i = 0; i < 10; i++) exp_bytes.push_back(8'h11 * 8'(i + 1));
    do_load(16'd10, 1'b0, 1'b1);
    #1;
    check(byte_left == 16'd10, "R8 load count", {16'h0, byte_left}, 32'd10);
    check(stat_tx == 5'b10011, "R11 tx occ 3", {27'h0, stat_tx}, 32'b10011);
    check(stat_rx == 5'h0, "R12 rx hidden in tx", {27'h0, stat_rx}, 32'h0);
    run_tx(100);
    #1;
    check(exp_bytes.size() == 0, "R6 all tx bytes sent", exp_bytes.size(), 0);
    check(card_out_valid == 1'b0, "R6 stop mid word", {31'h0, card_out_valid}, 32'h0);
    check(data_end == 1'b1, "R9 data_end tx", {31'h0, data_end}, 32'h1);
    @(negedge clk); #1;
    check(eng_en == 1'b0, "R10 tx self clear", {31'h0, eng_en}, 32'h0);
    check(stat_tx == 5'h0, "R10 flags cleared", {27'h0, stat_tx}, 32'h0);

    // R3 / R4 / R5 / R7: receive of 7 bytes
    do_load(16'd7, 1'b1, 1'b1);
    #1;
    check(stat_rx == 5'b01001, "R11 rx empty", {27'h0, stat_rx}, 32'b01001);
    check(stat_tx == 5'h0, "R12 tx hidden in rx", {27'h0, stat_tx}, 32'h0);
    check(card_in_ack == 1'b0, "R5 no ready no ack", {31'h0, card_in_ack}, 32'h0);
    for (int i = 0; i < 4; i++) feed_byte(8'h11 + 8'(i));
    @(negedge clk); @(negedge clk); #1;
    check(byte_left == 16'd3, "R5 R7 count holds while idle", {16'h0, byte_left}, 32'd3);
    for (int i = 4; i < 7; i++) feed_byte(8'h11 + 8'(i));
    exp_words.push_back(32'h1413_1211);
    exp_words.push_back(32'h0017_1615);
    #1;
    check(byte_left == 16'd0, "R7 rx count zero", {16'h0, byte_left}, 32'h0);
    check(stat_rx == 5'b10001, "R4 R11 two words held", {27'h0, stat_rx}, 32'b10001);
    check(eng_en == 1'b1, "R10 stays on until drained", {31'h0, eng_en}, 32'h1);
    tag = "R3 R4 rx packing";
    pop_w(); pop_w();
    @(negedge clk); #1;
    check(eng_en == 1'b0, "R10 rx self clear", {31'h0, eng_en}, 32'h0);

    // R5 full stall, R1 concurrent push and pop, R8 partial discard
    do_load(16'd80, 1'b1, 1'b1);
    for (int k = 0; k < 18; k++)
      exp_words.push_back({rb(4*k+3), rb(4*k+2), rb(4*k+1), rb(4*k)});
    for (int i = 0; i < 64; i++) feed_byte(rb(i));
    #1;
    check(stat_rx == 5'b10111, "R11 rx full", {27'h0, stat_rx}, 32'b10111);
    card_rdy = 1'b1; card_in_data = rb(64);
    #1 check(card_in_ack == 1'b0, "R5 refuse when full", {31'h0, card_in_ack}, 32'h0);
    @(negedge clk);
    card_rdy = 1'b0;
    #1 check(byte_left == 16'd16, "R5 count held when full", {16'h0, byte_left}, 32'd16);
    tag = "R1 rx word order";
    pop_w();
    for (int i = 64; i < 67; i++) feed_byte(rb(i));
    h_pop = 1'b1; card_rdy = 1'b1; card_in_data = rb(67);
    #1 check(card_in_ack == 1'b1, "R1 ack with pop", {31'h0, card_in_ack}, 32'h1);
    @(negedge clk);
    h_pop = 1'b0; card_rdy = 1'b0;
    for (int i = 68; i < 72; i++) feed_byte(rb(i));
    #1;
    check(stat_rx == 5'b10111, "R1 push and pop same cycle", {27'h0, stat_rx}, 32'b10111);
    check(byte_left == 16'd8, "R7 count after 72", {16'h0, byte_left}, 32'd8);
    for (int i = 0; i < 16; i++) pop_w();
    feed_byte(8'hAA); feed_byte(8'hBB);
    #1 check(byte_left == 16'd6, "R7 count after partial", {16'h0, byte_left}, 32'd6);
    do_load(16'd4, 1'b1, 1'b1);
    #1 check(byte_left == 16'd4, "R8 reload count", {16'h0, byte_left}, 32'd4);
    for (int i = 0; i < 4; i++) feed_byte(8'hC1 + 8'(i));
    exp_words.push_back(32'hC4C3_C2C1);
    tag = "R8 partial discarded";
    pop_w();
    #1 check(data_end == 1'b1, "R9 data_end rx", {31'h0, data_end}, 32'h1);
    @(negedge clk); #1;
    check(eng_en == 1'b0, "R10 clear after reload", {31'h0, eng_en}, 32'h0);

    // R11 transmit threshold boundary at 9 and 8 words
    for (int i = 0; i < 9; i++) begin
      logic [31:0] w;
      w = 32'h3020_1000 + 32'(i) * 32'h0101_0101;
      push_w(w);
      for (int j = 0; j < 4; j++) exp_bytes.push_back(w[j*8 +: 8]);
    end
    do_load(16'd36, 1'b0, 1'b1);
    #1;
    check(stat_tx == 5'b10001, "R11 tx occ 9", {27'h0, stat_tx}, 32'b10001);
    check(stat_rx == 5'h0, "R12 rx hidden", {27'h0, stat_rx}, 32'h0);
    @(negedge clk); #1;
    check(stat_tx == 5'b10011, "R11 tx occ 8", {27'h0, stat_tx}, 32'b10011);
    run_tx(200);
    #1 check(exp_bytes.size() == 0, "R6 36 bytes sent", exp_bytes.size(), 0);
    @(negedge clk); #1;
    check(eng_en == 1'b0, "R10 tx done", {31'h0, eng_en}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule